// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a sum-of-products programmable logic array. It takes the OR of its product terms, a per-cell enable term, and the array-wide asynchronous clear and synchronous set terms. Four configuration bits shape its behaviour. The cell drives a pin, modelled as separate out, enable and in signals, and it returns a feedback bit to the array. The bits choose a registered or pass-through output, the output polarity, which of two clocks loads the flip-flop, and whether the feedback comes from the flip-flop or from the pin.

A configuration bit that is left unprogrammed reads as 1, and each selector takes its 1 path by default. The flip-flop starts low while `por_n_i` is held low at power-up. Clear and set act on the flip-flop state, not on the pin, so the pin level that follows a clear depends on the chosen polarity. The bench changes the configuration only while the clear term is asserted.

Top module: `pal_macrocell`

## Requirements
- R1: While `por_n_i` is low the flip-flop is held at 0, so a registered cell with bit 0 = 0 drives `pin_out_o` = 1.
- R2: When `areset_i` is high the flip-flop goes to 0 at once, with no clock edge needed.
- R3: When `spreset_i` is high at a rising edge of the selected clock, the flip-flop loads 1 and ignores `sop_i`.
- R4: When `areset_i` and `spreset_i` are both high, the flip-flop stays at 0.
- R5: With bit 1 = 0 (registered), the flip-flop loads `sop_i` on each rising edge of the selected clock, and the output shows the flip-flop.
- R6: With bit 1 = 1 (bypass), the output follows `sop_i` in the same cycle, with no clock edge needed.
- R7: Bit 0 = 1 drives the selected value onto `pin_out_o` as it is, and bit 0 = 0 drives it inverted. This holds in both registered and bypass modes.
- R8: Bit 2 = 1 clocks the flip-flop from `clk_a_i` and bit 2 = 0 clocks it from `clk_b_i`. Edges of the clock that is not selected leave the flip-flop unchanged.
- R9: With bit 3 = 1, `fb_o` carries the flip-flop in registered mode and `pin_in_i` in bypass mode. With bit 3 = 0 the two sources are swapped.
- R10: `pin_oe_o` follows `oe_term_i`. With the buffer disabled and pin feedback selected, `fb_o` follows whatever is driven on `pin_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | First clock, used when bit 2 = 1 |
| clk_b_i | input | 1 | Second clock, used when bit 2 = 0 |
| por_n_i | input | 1 | Power-up initialisation, active low |
| cfg_i | input | CFG_W (4) | Configuration: bit 0 polarity, bit 1 bypass, bit 2 clock select, bit 3 feedback swap |
| sop_i | input | 1 | OR of the cell's product terms |
| oe_term_i | input | 1 | Output-enable product term |
| areset_i | input | 1 | Array-wide asynchronous clear term |
| spreset_i | input | 1 | Array-wide synchronous set term |
| pin_in_i | input | 1 | Level observed on the pin |
| pin_out_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Tristate enable for the pin driver |
| fb_o | output | 1 | Feedback bit into the logic array |

## Verification
The bench drives each input shortly after a cycle begins. The first clock rises at mid-cycle and the second clock rises a quarter cycle later. Pass-through outputs, the enable and the feedback are due in the same cycle, and the bench checks them right after driving. A clear is due at once, before either clock edge. A registered result is due only after the selected clock's edge. For that reason the bench samples once between the two edges and once after both. At the first sample a cell on the second clock must still show its old state, and a cell on the first clock must already show the new one.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
   // Configuration bit positions (unprogrammed bit reads 1)
   localparam int unsigned CFG_POL  = 0;
   localparam int unsigned CFG_BYP  = 1;
   localparam int unsigned CFG_CLK  = 2;
   localparam int unsigned CFG_FBX  = 3;
   localparam int unsigned CFG_BITS = 4;

   typedef enum logic {
      FB_FROM_REG = 1'b0,
      FB_FROM_PIN = 1'b1
   } fb_src_e;
endpackage

// File: rtl/pal_mc_clksel.sv
module pal_mc_clksel (
   input  logic clk_a_i,
   input  logic clk_b_i,
   input  logic sel_a_i,
   output logic clk_o
);
   always_comb begin
      clk_o = sel_a_i ? clk_a_i : clk_b_i;
   end
endmodule

// File: rtl/pal_mc_dff.sv
module pal_mc_dff #(
   parameter logic INIT_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic set_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk_i or posedge clr_i) begin
      if (clr_i)      q_o <= INIT_VAL;
      else if (set_i) q_o <= 1'b1;
      else            q_o <= d_i;
   end
endmodule

// File: rtl/pal_mc_outpath.sv
module pal_mc_outpath (
   input  logic bypass_i,
   input  logic active_high_i,
   input  logic sop_i,
   input  logic q_i,
   output logic out_o
);
   logic pre_pol;

   always_comb begin
      pre_pol = bypass_i ? sop_i : q_i;
      out_o   = active_high_i ? pre_pol : ~pre_pol;
   end
endmodule

// File: rtl/pal_mc_fbsel.sv
module pal_mc_fbsel
   import pal_mc_pkg::*;
#(
   parameter bit HAS_FB_SWAP = 1'b1
) (
   input  logic bypass_i,
   input  logic swap_n_i,
   input  logic q_i,
   input  logic pin_i,
   output logic fb_o
);
   fb_src_e src;

   generate
      if (HAS_FB_SWAP) begin : g_swap
         // swap_n_i = 1 keeps the natural pairing, 0 inverts it
         always_comb begin
            src = (bypass_i ~^ swap_n_i) ? FB_FROM_PIN : FB_FROM_REG;
         end
      end else begin : g_fixed
         logic unused_swap;
         always_comb begin
            unused_swap = swap_n_i;
            src = bypass_i ? FB_FROM_PIN : FB_FROM_REG;
         end
      end
   endgenerate

   always_comb begin
      fb_o = (src == FB_FROM_PIN) ? pin_i : q_i;
   end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
   import pal_mc_pkg::*;
#(
   parameter int unsigned CFG_W       = 4,
   parameter bit          HAS_FB_SWAP = 1'b1
) (
   input  logic             clk_a_i,
   input  logic             clk_b_i,
   input  logic             por_n_i,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic             sop_i,
   input  logic             oe_term_i,
   input  logic             areset_i,
   input  logic             spreset_i,
   input  logic             pin_in_i,
   output logic             pin_out_o,
   output logic             pin_oe_o,
   output logic             fb_o
);
   localparam int unsigned SPARE_W = CFG_W - CFG_BITS;

   generate
      if (CFG_W < CFG_BITS) begin : g_bad_cfg_w
         $error("pal_macrocell: CFG_W must be at least %0d", CFG_BITS);
      end
      if (SPARE_W > 0) begin : g_spare
         logic [SPARE_W-1:0] unused_cfg;
         always_comb unused_cfg = cfg_i[CFG_W-1:CFG_BITS];
      end
   endgenerate

   logic sel_clk;
   logic st_clr;
   logic st_q;

   always_comb begin
      st_clr   = areset_i | ~por_n_i;
      pin_oe_o = oe_term_i;
   end

   pal_mc_clksel u_clksel (
      .clk_a_i (clk_a_i),
      .clk_b_i (clk_b_i),
      .sel_a_i (cfg_i[CFG_CLK]),
      .clk_o   (sel_clk)
   );

   pal_mc_dff #(.INIT_VAL(1'b0)) u_dff (
      .clk_i (sel_clk),
      .clr_i (st_clr),
      .set_i (spreset_i),
      .d_i   (sop_i),
      .q_o   (st_q)
   );

   pal_mc_outpath u_out (
      .bypass_i      (cfg_i[CFG_BYP]),
      .active_high_i (cfg_i[CFG_POL]),
      .sop_i         (sop_i),
      .q_i           (st_q),
      .out_o         (pin_out_o)
   );

   pal_mc_fbsel #(.HAS_FB_SWAP(HAS_FB_SWAP)) u_fb (
      .bypass_i (cfg_i[CFG_BYP]),
      .swap_n_i (cfg_i[CFG_FBX]),
      .q_i      (st_q),
      .pin_i    (pin_in_i),
      .fb_o     (fb_o)
   );
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk
   import pal_mc_pkg::*;
#(
   parameter int unsigned CFG_W = 4
) (
   input logic             clk_a_i,
   input logic             clk_b_i,
   input logic             por_n_i,
   input logic [CFG_W-1:0] cfg_i,
   input logic             sop_i,
   input logic             areset_i,
   input logic             spreset_i,
   input logic             st_q
);
   // R1
   por_holds_low_chk: assert property (@(posedge clk_a_i)
      !por_n_i |-> (st_q == 1'b0));

   // R2
   areset_clears_chk: assert property (@(posedge clk_a_i)
      areset_i |-> (st_q == 1'b0));

   // R4
   clear_beats_set_chk: assert property (@(posedge clk_b_i)
      (areset_i && spreset_i) |-> (st_q == 1'b0));

   // R3
   preset_sets_chk: assert property (@(posedge clk_a_i)
      disable iff (areset_i || !por_n_i)
      (cfg_i[CFG_CLK] && spreset_i) |=> (st_q == 1'b1));

   // R5
   capture_a_chk: assert property (@(posedge clk_a_i)
      disable iff (areset_i || !por_n_i)
      (cfg_i[CFG_CLK] && !spreset_i) |=> (st_q == $past(sop_i)));

   // R8
   capture_b_chk: assert property (@(posedge clk_b_i)
      disable iff (areset_i || !por_n_i)
      (!cfg_i[CFG_CLK] && !spreset_i) |=> (st_q == $past(sop_i)));
endmodule

bind pal_macrocell pal_macrocell_chk #(.CFG_W(CFG_W)) chk_i (.*);

// File: tb/pal_macrocell_tb_top.sv
module pal_macrocell_tb_top;
   logic       clk_a = 1'b0;
   logic       clk_b = 1'b0;
   logic       por_n = 1'b0;
   logic [3:0] cfg   = 4'hF;
   logic       sop   = 1'b0;
   logic       oe    = 1'b0;
   logic       ar    = 1'b0;
   logic       sp    = 1'b0;
   logic       pin   = 1'b0;
   logic       pin_out, pin_oe, fb;

   int unsigned n_chk  = 0;
   int unsigned n_fail = 0;
   logic        mq     = 1'b0;

   pal_macrocell dut_i (
      .clk_a_i   (clk_a),
      .clk_b_i   (clk_b),
      .por_n_i   (por_n),
      .cfg_i     (cfg),
      .sop_i     (sop),
      .oe_term_i (oe),
      .areset_i  (ar),
      .spreset_i (sp),
      .pin_in_i  (pin),
      .pin_out_o (pin_out),
      .pin_oe_o  (pin_oe),
      .fb_o      (fb)
   );

   // 50 MHz; clk_a rises at 10+20k, clk_b rises at 15+20k
   initial forever #10 clk_a = ~clk_a;
   initial begin #5; forever #10 clk_b = ~clk_b; end

   function automatic logic exp_out(logic [3:0] c, logic s, logic q);
      logic v;
      v = c[1] ? s : q;
      return c[0] ? v : ~v;
   endfunction

   function automatic logic exp_fb(logic [3:0] c, logic p, logic q);
      logic use_pin;
      use_pin = c[3] ? c[1] : ~c[1];
      return use_pin ? p : q;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic check_all(input string phase);
      string otag;
      if (!por_n)            otag = "R1";
      else if (ar && sp)     otag = "R4";
      else if (ar)           otag = "R2";
      else if (sp && !cfg[1]) otag = "R3";
      else if (phase == "mid" && !cfg[1]) otag = "R8";
      else if (cfg[1])       otag = "R6 R7";
      else                   otag = "R5 R7";
      chk({otag, " pin_out ", phase}, pin_out, exp_out(cfg, sop, mq));
      chk({"R10 pin_oe ", phase}, pin_oe, oe);
      chk({"R9 fb ", phase}, fb, exp_fb(cfg, pin, mq));
   endtask

   // Called at 20k+1; returns at 20(k+1)+1
   task automatic step(input logic [3:0] c, input logic s, input logic o,
                       input logic a, input logic p_set, input logic p_in,
                       input logic pwr);
      logic clr;
      cfg = c; sop = s; oe = o; ar = a; sp = p_set; pin = p_in; por_n = pwr;
      clr = a | ~pwr;
      if (clr) mq = 1'b0;
      #1;
      check_all("early");
      #10;                                  // 20k+12, clk_a edge done
      if (c[2] && !clr) mq = p_set ? 1'b1 : s;
      check_all("mid");
      #7;                                   // 20k+19, clk_b edge done
      if (!c[2] && !clr) mq = p_set ? 1'b1 : s;
      check_all("end");
      #2;
   endtask

   initial begin
      #4_000_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] r;
      r = $urandom(32'd2718);
      #1;
      // R1: power-up, registered active-low cell drives 1
      step(4'b1100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      step(4'b1100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      // R5: first capture after power-up
      step(4'b1100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      // R4: clear and set together
      step(4'b1101, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      // R3: set while sop low, on each clock
      step(4'b1101, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      step(4'b1001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      step(4'b1001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      // R10: buffer off, pin used as input
      step(4'b1011, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      step(4'b1011, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      step(4'b1011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      // All configurations (8 output modes x 2 clocks)
      for (int c = 0; c < 16; c++) begin
         // configuration changes only under clear
         step(c[3:0], 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
         for (int k = 0; k < 12; k++) begin
            r = $urandom;
            step(c[3:0], r[0], r[1], (r[4:2] == 3'd0), (r[7:5] == 3'd0),
                 r[8], 1'b1);
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule